// File: doc/BRIEF.md
# MAC Address Table Command Engine

This block keeps a small, fully associative forwarding table. Each entry is keyed by a 16-bit VLAN ID combined with a 48-bit MAC address and holds a destination field, an address type and a locked flag. A host reaches the table through four 32-bit registers: a high key word, a low key word, an attribute word and a command word. The host fills the key and attribute registers, then writes the command word with its start bit set. The engine then runs the command against the table and puts any result back into the key and attribute registers.

The engine supports five commands: learn (insert or update), unlearn, exact lookup, find-next-smallest and clear-all. Find-next-smallest returns the entry whose key is the smallest one strictly above the key now in the registers. Software can walk the whole table in key order by issuing it repeatedly, because each hit leaves the found key in the registers. While a command runs, the start bit reads back as 1. Search commands visit one table entry per clock cycle.

Register map, selected by a 2-bit address: 0 is the high key (VID in bits 31:16, MAC bytes 0 and 1 in bits 15:0), 1 is the low key (MAC bytes 2 to 5, with byte 2 in bits 31:24), 2 is the attribute word and 3 is the command word.

Top module: `mact_engine`

## Requirements
- R1: After reset, all four registers read 0, the sticky table-full flag is clear, and the table holds no valid entry.
- R2: Writing the command word with bit 31 set starts the command selected by bits 2:0. Bit 31 then reads 1 until the command finishes and 0 afterwards. Opcodes 0, 1, 2 and 6 stay busy for exactly ENTRIES+1 cycles. All other opcodes stay busy for 1 cycle.
- R3: Learn (opcode 0) of a key not yet in the table stores that key with the attribute register's fields: destination in bits 11:0, type in bits 13:12, locked in bit 17. A later lookup of the key returns those fields with the valid bit (bit 16) set.
- R4: Learn of a key already in the table replaces its attributes and does not take a second slot.
- R5: Lookup (opcode 2) of a key that is not in the table clears bit 16 of the attribute register, keeps its other bits, and leaves both key registers unchanged.
- R6: Unlearn (opcode 1) removes the matching entry, so a later lookup of that key misses.
- R7: Find (opcode 6) loads into the key registers the smallest valid key that is strictly greater than the 64-bit value {VID, MAC} now held there. It also loads that entry's attributes with bit 16 set.
- R8: When no greater key exists, find clears bit 16 of the attribute register and leaves the key registers unchanged.
- R9: When bit 8 of the command word is set, find skips entries whose locked bit is set. When bit 8 is clear, locked entries are included.
- R10: Learn of a new key while all ENTRIES slots are valid leaves the table unchanged and sets bit 16 of the command word. That bit stays set through later commands.
- R11: Clear-all (opcode 7) invalidates every entry and clears the table-full flag.
- R12: Register writes made while bit 31 of the command word reads 1 are ignored.
- R13: Opcodes 3, 4 and 5 change neither the table nor the key and attribute registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register select for the read |
| rd_data | output | 32 | Read data of the selected register (combinational) |

## Verification
The hardest condition to reach from the ports is a completely full table meeting a learn of a fresh key. A test can only get there after ENTRIES distinct learns, and only if no unlearn or clear-all has run in between. The stimulus fills the table with random keys that are distinct by construction, tracked in a bench model. It then offers one more new key and walks the table with find to confirm that nothing was displaced. Boundary walks cover two more cases that ports alone reach only indirectly: a find with no greater key, and a find with the skip-locked bit set.

// File: rtl/mact_pkg.sv
package mact_pkg;

    localparam int DEST_W = 12;

    typedef enum logic [2:0] {
        OP_LEARN   = 3'd0,
        OP_UNLEARN = 3'd1,
        OP_LOOKUP  = 3'd2,
        OP_RD_IDX  = 3'd3,
        OP_WR_IDX  = 3'd4,
        OP_SCAN    = 3'd5,
        OP_FIND    = 3'd6,
        OP_CLEAR   = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DONE
    } eng_state_e;

    typedef struct packed {
        logic [15:0] vid;
        logic [47:0] mac;
    } key_t;

    typedef struct packed {
        logic              locked;
        logic              valid;
        logic [1:0]        atype;
        logic [DEST_W-1:0] dest;
    } attr_t;

    function automatic key_t key_from_words(input logic [31:0] hi, input logic [31:0] lo);
        key_t k;
        k.vid = hi[31:16];
        k.mac = {hi[15:0], lo};
        return k;
    endfunction

    function automatic attr_t attr_from_word(input logic [31:0] w);
        attr_t a;
        a.dest   = w[DEST_W-1:0];
        a.atype  = w[13:12];
        a.valid  = w[16];
        a.locked = w[17];
        return a;
    endfunction

    function automatic logic [31:0] attr_to_word(input attr_t a);
        logic [31:0] w;
        w = '0;
        w[DEST_W-1:0] = a.dest;
        w[13:12]      = a.atype;
        w[16]         = a.valid;
        w[17]         = a.locked;
        return w;
    endfunction

    function automatic logic op_scans(input opcode_e op);
        return (op == OP_LEARN) || (op == OP_UNLEARN) ||
               (op == OP_LOOKUP) || (op == OP_FIND);
    endfunction

endpackage

// File: rtl/mact_store.sv
module mact_store
    import mact_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   rd_idx,
    output key_t               rd_key,
    output attr_t              rd_attr,
    output logic               rd_valid,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  key_t               wkey,
    input  attr_t              wattr,
    input  logic               inval,
    input  logic [IDX_W-1:0]   iidx,
    input  logic               clr,
    output logic [ENTRIES-1:0] valid_vec
);

    key_t               keys  [ENTRIES];
    attr_t              attrs [ENTRIES];
    logic [ENTRIES-1:0] vld;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld <= '0;
        end else begin
            if (we)    vld[widx] <= 1'b1;
            if (inval) vld[iidx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            keys[widx]  <= wkey;
            attrs[widx] <= wattr;
        end
    end

    assign rd_key    = keys[rd_idx];
    assign rd_attr   = attrs[rd_idx];
    assign rd_valid  = vld[rd_idx];
    assign valid_vec = vld;

    // one command can add at most one entry
    assert_grow_one_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> ($countones(vld) <= $countones($past(vld)) + 1));

    assert_clear_empty_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (vld == '0));

endmodule

// File: rtl/mact_ctrl.sv
module mact_ctrl
    import mact_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  opcode_e          op_in,
    input  logic             skip_in,
    input  key_t             key_in,
    input  attr_t            attr_in,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] rd_idx,
    input  key_t             rd_key,
    input  attr_t            rd_attr,
    input  logic             rd_valid,
    output logic             st_we,
    output logic [IDX_W-1:0] st_widx,
    output key_t             st_wkey,
    output attr_t            st_wattr,
    output logic             st_inval,
    output logic [IDX_W-1:0] st_iidx,
    output logic             st_clr,
    output logic             upd_key,
    output key_t             new_key,
    output logic             upd_attr,
    output attr_t            new_attr,
    output logic             full_set,
    output logic             full_clr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
    localparam int               CNT_W    = $clog2(ENTRIES + 3);

    eng_state_e       st;
    opcode_e          op_r;
    logic             skip_r;
    logic [IDX_W-1:0] idx;
    logic             hit, free_ok, best_ok;
    logic [IDX_W-1:0] hit_idx, free_idx;
    attr_t            hit_attr, best_attr;
    key_t             best_key;

    logic cand_match, cand_free, cand_better;

    always_comb begin
        cand_match  = rd_valid && (rd_key == key_in);
        cand_free   = !rd_valid;
        cand_better = rd_valid && !(skip_r && rd_attr.locked) &&
                      (rd_key > key_in) && (!best_ok || (rd_key < best_key));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            op_r      <= OP_LEARN;
            skip_r    <= 1'b0;
            idx       <= '0;
            hit       <= 1'b0;
            free_ok   <= 1'b0;
            best_ok   <= 1'b0;
            hit_idx   <= '0;
            free_idx  <= '0;
            hit_attr  <= '0;
            best_attr <= '0;
            best_key  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    op_r    <= op_in;
                    skip_r  <= skip_in;
                    idx     <= '0;
                    hit     <= 1'b0;
                    free_ok <= 1'b0;
                    best_ok <= 1'b0;
                    st      <= op_scans(op_in) ? ST_SCAN : ST_DONE;
                end
                ST_SCAN: begin
                    if (cand_match && !hit) begin
                        hit      <= 1'b1;
                        hit_idx  <= idx;
                        hit_attr <= rd_attr;
                    end
                    if (cand_free && !free_ok) begin
                        free_ok  <= 1'b1;
                        free_idx <= idx;
                    end
                    if (cand_better) begin
                        best_ok   <= 1'b1;
                        best_key  <= rd_key;
                        best_attr <= rd_attr;
                    end
                    if (idx == LAST_IDX) st <= ST_DONE;
                    else                 idx <= idx + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (st != ST_IDLE);
    assign done    = (st == ST_DONE);
    assign rd_idx  = idx;
    assign st_wkey = key_in;
    assign st_iidx = hit_idx;
    assign new_key = best_key;

    always_comb begin
        st_we           = 1'b0;
        st_widx         = hit_idx;
        st_wattr        = attr_in;
        st_wattr.valid  = 1'b1;
        st_inval        = 1'b0;
        st_clr          = 1'b0;
        upd_key         = 1'b0;
        upd_attr        = 1'b0;
        new_attr        = attr_in;
        new_attr.valid  = 1'b0;
        full_set        = 1'b0;
        full_clr        = 1'b0;
        if (st == ST_DONE) begin
            case (op_r)
                OP_LEARN: begin
                    if (hit) begin
                        st_we = 1'b1;
                    end else if (free_ok) begin
                        st_we   = 1'b1;
                        st_widx = free_idx;
                    end else begin
                        full_set = 1'b1;
                    end
                end
                OP_UNLEARN: st_inval = hit;
                OP_LOOKUP: begin
                    upd_attr = 1'b1;
                    if (hit) begin
                        new_attr       = hit_attr;
                        new_attr.valid = 1'b1;
                    end
                end
                OP_FIND: begin
                    upd_attr = 1'b1;
                    if (best_ok) begin
                        upd_key        = 1'b1;
                        new_attr       = best_attr;
                        new_attr.valid = 1'b1;
                    end
                end
                OP_CLEAR: begin
                    st_clr   = 1'b1;
                    full_clr = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // busy window watcher for the completion bound
    logic [CNT_W-1:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + 1'b1;
    end

    assert_busy_bound_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt <= CNT_W'(ENTRIES)));

    assert_done_release_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/mact_engine.sv
module mact_engine
    import mact_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    localparam logic [1:0] A_KEY_HI = 2'd0;
    localparam logic [1:0] A_KEY_LO = 2'd1;
    localparam logic [1:0] A_ATTR   = 2'd2;
    localparam logic [1:0] A_CMD    = 2'd3;

    logic [31:0] key_hi_q, key_lo_q;
    attr_t       attr_q;
    opcode_e     op_q;
    logic        skip_q, full_q;

    logic             busy, done, start;
    logic [IDX_W-1:0] rd_idx, st_widx, st_iidx;
    key_t             rd_key, st_wkey, new_key, key_cur;
    attr_t            rd_attr, st_wattr, new_attr;
    logic             rd_valid, st_we, st_inval, st_clr;
    logic             upd_key, upd_attr, full_set, full_clr;
    logic [ENTRIES-1:0] valid_vec;

    assign key_cur = key_from_words(key_hi_q, key_lo_q);
    assign start   = !busy && wr_en && (wr_addr == A_CMD) && wr_data[31];

    always_ff @(posedge clk) begin
        if (rst) begin
            key_hi_q <= '0;
            key_lo_q <= '0;
            attr_q   <= '0;
            op_q     <= OP_LEARN;
            skip_q   <= 1'b0;
            full_q   <= 1'b0;
        end else begin
            if (!busy && wr_en) begin
                case (wr_addr)
                    A_KEY_HI: key_hi_q <= wr_data;
                    A_KEY_LO: key_lo_q <= wr_data;
                    A_ATTR:   attr_q   <= attr_from_word(wr_data);
                    default: begin
                        op_q   <= opcode_e'(wr_data[2:0]);
                        skip_q <= wr_data[8];
                    end
                endcase
            end
            if (upd_key) begin
                key_hi_q <= {new_key.vid, new_key.mac[47:32]};
                key_lo_q <= new_key.mac[31:0];
            end
            if (upd_attr) attr_q <= new_attr;
            if (full_set)      full_q <= 1'b1;
            else if (full_clr) full_q <= 1'b0;
        end
    end

    always_comb begin
        case (rd_addr)
            A_KEY_HI: rd_data = key_hi_q;
            A_KEY_LO: rd_data = key_lo_q;
            A_ATTR:   rd_data = attr_to_word(attr_q);
            default: begin
                rd_data      = '0;
                rd_data[31]  = busy;
                rd_data[16]  = full_q;
                rd_data[8]   = skip_q;
                rd_data[2:0] = op_q;
            end
        endcase
    end

    mact_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op_in    (opcode_e'(wr_data[2:0])),
        .skip_in  (wr_data[8]),
        .key_in   (key_cur),
        .attr_in  (attr_q),
        .busy     (busy),
        .done     (done),
        .rd_idx   (rd_idx),
        .rd_key   (rd_key),
        .rd_attr  (rd_attr),
        .rd_valid (rd_valid),
        .st_we    (st_we),
        .st_widx  (st_widx),
        .st_wkey  (st_wkey),
        .st_wattr (st_wattr),
        .st_inval (st_inval),
        .st_iidx  (st_iidx),
        .st_clr   (st_clr),
        .upd_key  (upd_key),
        .new_key  (new_key),
        .upd_attr (upd_attr),
        .new_attr (new_attr),
        .full_set (full_set),
        .full_clr (full_clr)
    );

    mact_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (rd_idx),
        .rd_key    (rd_key),
        .rd_attr   (rd_attr),
        .rd_valid  (rd_valid),
        .we        (st_we),
        .widx      (st_widx),
        .wkey      (st_wkey),
        .wattr     (st_wattr),
        .inval     (st_inval),
        .iidx      (st_iidx),
        .clr       (st_clr),
        .valid_vec (valid_vec)
    );

    // the full flag may only rise after a cycle with every slot in use
    assert_full_only_when_full_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(full_q) |-> $past(&valid_vec));

    assert_busy_write_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && wr_en) |=>
            ($stable(key_hi_q) && $stable(key_lo_q) && $stable(attr_q)));

endmodule

// File: tb/mact_engine_tb.sv
module mact_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] mk [N];
    logic [31:0] ma [N];
    bit          mv [N];

    mact_engine #(.ENTRIES(N)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_key(output logic [63:0] k);
        logic [31:0] h, l;
        reg_rd(0, h);
        reg_rd(1, l);
        k = {h, l};
    endtask

    task automatic set_key(input logic [63:0] k);
        reg_wr(0, k[63:32]);
        reg_wr(1, k[31:0]);
    endtask

    task automatic run_cmd(input int op, input bit skip, output int cyc);
        logic [31:0] c;
        reg_wr(3, 32'h8000_0000 | (32'(skip) << 8) | 32'(op));
        cyc = 0;
        for (int g = 0; g < 1000; g++) begin
            reg_rd(3, c);
            if (!c[31]) break;
            cyc++;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] mk_attr(input logic [11:0] d, input logic [1:0] t, input bit lk);
        return (32'(lk) << 17) | (32'(t) << 12) | 32'(d);
    endfunction

    function automatic int mdl_idx(input logic [63:0] k);
        for (int i = 0; i < N; i++) if (mv[i] && mk[i] == k) return i;
        return -1;
    endfunction

    function automatic int mdl_count();
        int c = 0;
        for (int i = 0; i < N; i++) if (mv[i]) c++;
        return c;
    endfunction

    function automatic int mdl_next(input logic [63:0] r, input bit skip);
        int b = -1;
        for (int i = 0; i < N; i++)
            if (mv[i] && !(skip && ma[i][17]) && mk[i] > r && (b < 0 || mk[i] < mk[b])) b = i;
        return b;
    endfunction

    function automatic logic [63:0] rnd_key();
        logic [15:0] v = 16'($urandom_range(1, 4));
        logic [47:0] m = {16'($urandom), $urandom};
        return {v, m};
    endfunction

    function automatic logic [63:0] new_key();
        logic [63:0] k;
        for (int t = 0; t < 100; t++) begin
            k = rnd_key();
            if (mdl_idx(k) < 0) break;
        end
        return k;
    endfunction

    task automatic learn(input logic [63:0] k, input logic [31:0] aw);
        int cyc, i;
        set_key(k);
        reg_wr(2, aw);
        run_cmd(0, 0, cyc);
        i = mdl_idx(k);
        if (i >= 0) ma[i] = aw;
        else begin
            for (int j = 0; j < N; j++)
                if (!mv[j]) begin mv[j] = 1; mk[j] = k; ma[j] = aw; break; end
        end
    endtask

    task automatic do_walk(input bit skip, input string tag);
        logic [63:0] r, k;
        logic [31:0] aw;
        int cyc, e, cnt;
        r = '0; cnt = 0;
        set_key(r);
        for (int g = 0; g < N + 2; g++) begin
            run_cmd(6, skip, cyc);
            e = mdl_next(r, skip);
            reg_rd(2, aw);
            rd_key(k);
            if (e < 0) begin
                check({tag, " R8 end valid"}, 64'(aw[16]), 64'd0);
                check({tag, " R8 key kept"}, k, r);
                break;
            end
            check({tag, " key"}, k, mk[e]);
            check({tag, " attr"}, 64'(aw), 64'(ma[e] | 32'h1_0000));
            r = mk[e];
            cnt++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, aw;
        logic [63:0] k, kx;
        int cyc, dummy;
        dummy = $urandom(32'h5EED_0042);
        for (int i = 0; i < N; i++) begin mv[i] = 0; mk[i] = '0; ma[i] = '0; end

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            reg_rd(2'(a), d);
            check("R1 reset register", 64'(d), 64'd0);
        end

        // R2 search latency, R3 learns
        set_key(rnd_key());
        k = {key_hi_dummy(), 32'd0};
        learn(new_key(), mk_attr(12'h011, 2'd0, 0));
        for (int i = 0; i < 9; i++)
            learn(new_key(), mk_attr(12'($urandom), 2'($urandom), bit'($urandom_range(0, 1))));
        k = new_key();
        set_key(k);
        run_cmd(2, 0, cyc);
        check("R2 search busy cycles", 64'(cyc), 64'(N + 1));
        reg_rd(3, d);
        check("R2 start bit cleared", 64'(d[31]), 64'd0);
        check("R10 full flag clear", 64'(d[16]), 64'd0);

        // R3 lookup hits
        for (int i = 0; i < N; i++) if (mv[i]) begin
            set_key(mk[i]);
            reg_wr(2, 32'h0000_0ABC);
            run_cmd(2, 0, cyc);
            reg_rd(2, aw);
            check("R3 lookup hit attr", 64'(aw), 64'(ma[i] | 32'h1_0000));
            rd_key(kx);
            check("R3 lookup key kept", kx, mk[i]);
        end

        // R4 overwrite
        learn(mk[0], mk_attr(12'h7E5, 2'd3, 1));
        set_key(mk[0]);
        run_cmd(2, 0, cyc);
        reg_rd(2, aw);
        check("R4 overwrite attr", 64'(aw), 64'(mk_attr(12'h7E5, 2'd3, 1) | 32'h1_0000));
        check("R4 slot count", 64'(mdl_count()), 64'd10);

        // R5 lookup miss
        k = new_key();
        set_key(k);
        reg_wr(2, 32'h0001_25A5);
        run_cmd(2, 0, cyc);
        reg_rd(2, aw);
        check("R5 miss attr", 64'(aw), 64'h0000_25A5);
        rd_key(kx);
        check("R5 miss key kept", kx, k);

        // R7 R8 walk, R9 skip-locked walk
        do_walk(0, "R7 walk");
        do_walk(1, "R9 skip walk");

        // R6 unlearn
        for (int n = 0; n < 2; n++) begin
            int i = mdl_idx(mk[n + 1]);
            set_key(mk[i]);
            run_cmd(1, 0, cyc);
            mv[i] = 0;
            run_cmd(2, 0, cyc);
            reg_rd(2, aw);
            check("R6 unlearned lookup valid", 64'(aw[16]), 64'd0);
        end
        do_walk(0, "R6 walk");

        // R13 inert opcodes
        set_key(mk[0]);
        reg_wr(2, 32'h0002_3123);
        for (int op = 3; op <= 5; op++) begin
            run_cmd(op, 0, cyc);
            check("R13 one cycle", 64'(cyc), 64'd1);
            rd_key(kx);
            check("R13 key kept", kx, mk[0]);
            reg_rd(2, aw);
            check("R13 attr kept", 64'(aw), 64'h0002_3123);
        end
        do_walk(0, "R13 walk");

        // R12 writes while busy
        set_key(mk[0]);
        reg_wr(3, 32'h8000_0002);
        reg_wr(0, 32'hDEAD_BEEF);
        reg_wr(2, 32'h0000_0FFF);
        for (int g = 0; g < 100; g++) begin
            reg_rd(3, d);
            if (!d[31]) break;
            @(negedge clk);
        end
        rd_key(kx);
        check("R12 key write ignored", kx, mk[0]);
        reg_rd(2, aw);
        check("R12 attr result", 64'(aw), 64'(ma[0] | 32'h1_0000));

        // R10 fill and overflow
        while (mdl_count() < N)
            learn(new_key(), mk_attr(12'($urandom), 2'($urandom), bit'($urandom_range(0, 1))));
        reg_rd(3, d);
        check("R10 flag clear at exactly full", 64'(d[16]), 64'd0);
        k = new_key();
        set_key(k);
        reg_wr(2, mk_attr(12'h123, 2'd1, 0));
        run_cmd(0, 0, cyc);
        reg_rd(3, d);
        check("R10 full flag set", 64'(d[16]), 64'd1);
        run_cmd(2, 0, cyc);
        reg_rd(2, aw);
        check("R10 overflow key absent", 64'(aw[16]), 64'd0);
        reg_rd(3, d);
        check("R10 flag sticky", 64'(d[16]), 64'd1);
        do_walk(0, "R10 walk");

        // R11 clear-all
        run_cmd(7, 0, cyc);
        check("R11 clear busy cycles", 64'(cyc), 64'd1);
        reg_rd(3, d);
        check("R11 flag cleared", 64'(d[16]), 64'd0);
        for (int i = 0; i < N; i++) mv[i] = 0;
        do_walk(0, "R11 walk");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    function automatic logic [31:0] key_hi_dummy();
        return 32'd0;
    endfunction

endmodule